// File: doc/BRIEF.md
# RTC Prescaler with Cycle Trim

This block turns a 32.768 kHz oscillator tick into the once-per-second advance enable that a calendar counter consumes. It also corrects slow or fast crystals. A signed trim is applied once per correction interval: the last second of each interval is shortened or stretched by a programmed number of oscillator cycles. The interval is either a short window (10 seconds by default) or a long window (60 seconds by default).

The same divider also produces a periodic event whose period is a power of two seconds, chosen by a 4-bit code. One code, for example, gives 1/64 second, which software uses to pace alarm setup. The event latches a sticky flag, and the flag is gated by an enable to form the interrupt line.

A ready indication tells software when the downstream counters may be read after the block first starts running out of reset. The oscillator is supplied as a single-cycle enable `osc_tick` in the system clock domain.

Top module: `rtc_prescaler`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `sec_tick`, `per_flag`, `per_irq` and `cnt_ready` are 0 and `trim_rdata` is 0x00.
- R2: A cycle with `osc_tick`=1 and `run`=1 is an advance; other cycles leave all counting state unchanged. With no correction in force, `sec_tick` pulses for exactly one cycle once every `TICKS_PER_SEC` advances. The pulse is visible the cycle after the advance that completes the second.
- R3: A cycle with `trim_we`=1 stores `trim_wdata`, and the stored byte reads back on `trim_rdata` from the next cycle. Bits 5:0 hold the cycle count N (0..63). Bits 7:6 hold the mode: 0 none, 1 add, 2 subtract. Mode 3 behaves as none.
- R4: With `auto_adj_en`=1 and mode add, the last second of each interval lasts `TICKS_PER_SEC`-N advances.
- R5: With `auto_adj_en`=1 and mode subtract, the last second of each interval lasts `TICKS_PER_SEC`+N advances.
- R6: The interval is `SHORT_SECS` seconds when the latched interval select is 1, and `LONG_SECS` seconds when it is 0. Seconds are counted from reset, and the interval's final second is the corrected one.
- R7: The `ivl_short` input is latched only in cycles where the stored mode field (bits 7:6) is 0. While the mode field is nonzero, a change on `ivl_short` has no effect.
- R8: With `auto_adj_en`=0, every second lasts `TICKS_PER_SEC` advances whatever the stored trim.
- R9: `per_code` selects the periodic event. Codes 6..13 give a period of 2^(code-14) s: the event fires on an advance whose next count value has its low log2(`TICKS_PER_SEC`)+code-14 bits all zero, and a wrap to zero counts. Code 14 fires on each second. Code 15 fires on every second second. Codes 0..5 never fire; code 8 is 1/64 s.
- R10: `per_flag` sets on each periodic event and holds until `per_clr`; when both occur in the same cycle, the set wins. `per_irq` is 1 exactly when `per_flag` and `per_ie` are both 1.
- R11: `cnt_ready` rises the cycle after the `TICKS_PER_SEC`/128-th advance since reset, i.e. 1/128 s of running, and stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | One-cycle pulse per oscillator cycle |
| run | input | 1 | Counting enable |
| auto_adj_en | input | 1 | Enables the per-interval trim |
| ivl_short | input | 1 | Interval select: 1 short, 0 long |
| trim_we | input | 1 | Write strobe for the trim byte |
| trim_wdata | input | 8 | Trim byte: mode in 7:6, count in 5:0 |
| trim_rdata | output | 8 | Stored trim byte |
| per_code | input | 4 | Periodic event period code |
| per_ie | input | 1 | Periodic interrupt enable |
| per_clr | input | 1 | Clears the periodic flag |
| sec_tick | output | 1 | One-cycle pulse per second |
| per_flag | output | 1 | Sticky periodic flag |
| per_irq | output | 1 | Periodic interrupt request |
| cnt_ready | output | 1 | Counters readable after start-up |

## Verification
The divider is exercised in two ways. A sparse `osc_tick` with `run` held high shows that only advances are counted. A dense tick shows back-to-back counting and exposes off-by-one errors in the second length. The trim is tried with add, subtract, reserved mode and the enable cleared. Second lengths are gathered over full 10- and 60-second windows, so an adjustment placed in the wrong second, applied twice, or applied with the wrong interval shows up as a wrong count of shortened or stretched seconds. Periodic codes with sub-second, one-second and two-second periods, plus a disabled code, are counted over whole seconds; a cycle-accurate model is compared on every clock to catch timing slips.

// File: rtl/rtc_presc_pkg.sv
package rtc_presc_pkg;

   typedef enum logic [1:0] {
      TRIM_NONE = 2'd0,
      TRIM_ADD  = 2'd1,
      TRIM_SUB  = 2'd2,
      TRIM_RSVD = 2'd3
   } trim_mode_e;

   typedef struct packed {
      trim_mode_e mode;
      logic [5:0] cycles;
   } trim_t;

   // periodic selector code points
   localparam int PER_CODE_MIN     = 6;
   localparam int PER_CODE_ONE_SEC = 14;
   localparam int PER_CODE_TWO_SEC = 15;

   // smallest divider that keeps every sub-second tap and the ready delay meaningful
   localparam int MIN_LOG2_TICKS = 8;

endpackage

// File: rtl/presc_trim_reg.sv
module presc_trim_reg
   import rtc_presc_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  we,
   input  trim_t wdata,
   input  logic  ivl_short_in,
   output trim_t trim_q,
   output logic  ivl_short_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         trim_q      <= '{mode: TRIM_NONE, cycles: 6'd0};
         ivl_short_q <= 1'b0;
      end else begin
         if (we)
            trim_q <= wdata;
         if (trim_q.mode == TRIM_NONE)
            ivl_short_q <= ivl_short_in;
      end
   end

   // R3
   trim_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (trim_q == $past(wdata)));

   // R7
   ivl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trim_q.mode != TRIM_NONE) |=> $stable(ivl_short_q));

endmodule

// File: rtl/presc_sec_div.sv
module presc_sec_div
   import rtc_presc_pkg::*;
#(
   parameter int unsigned TICKS_PER_SEC = 32768,
   parameter int unsigned SHORT_SECS    = 10,
   parameter int unsigned LONG_SECS     = 60
)(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  adv,
   input  logic  auto_adj_en,
   input  logic  ivl_short,
   input  trim_t trim,
   output logic  wrap,
   output logic  half,
   output logic  sec_tick,
   output logic [$clog2(TICKS_PER_SEC)-2:0] nxt_lo
);

   localparam int unsigned LOG2 = $clog2(TICKS_PER_SEC);
   localparam int unsigned CW   = LOG2 + 1;
   localparam int unsigned SW   = $clog2(LONG_SECS);
   localparam logic [CW-1:0] BASE_TERM  = CW'(TICKS_PER_SEC - 1);
   localparam logic [CW-1:0] MAX_CNT    = CW'(TICKS_PER_SEC + 62);
   localparam logic [SW-1:0] SHORT_LAST = SW'(SHORT_SECS - 1);
   localparam logic [SW-1:0] LONG_LAST  = SW'(LONG_SECS - 1);

   logic [CW-1:0] cnt_q, term, nxt, trim_ext;
   logic [SW-1:0] sidx_q, last_idx;
   logic          adj_sec, half_q, sec_q;

   assign last_idx = ivl_short ? SHORT_LAST : LONG_LAST;
   assign adj_sec  = auto_adj_en && (sidx_q >= last_idx);
   assign trim_ext = CW'(trim.cycles);

   always_comb begin
      term = BASE_TERM;
      if (adj_sec) begin
         case (trim.mode)
            TRIM_ADD: term = BASE_TERM - trim_ext;
            TRIM_SUB: term = BASE_TERM + trim_ext;
            default:  term = BASE_TERM;
         endcase
      end
   end

   assign wrap = adv && (cnt_q >= term);
   assign nxt  = wrap ? '0 : cnt_q + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         sidx_q <= '0;
         half_q <= 1'b0;
         sec_q  <= 1'b0;
      end else begin
         sec_q <= wrap;
         if (adv)
            cnt_q <= nxt;
         if (wrap) begin
            sidx_q <= (sidx_q >= last_idx) ? '0 : sidx_q + 1'b1;
            half_q <= ~half_q;
         end
      end
   end

   assign nxt_lo   = nxt[LOG2-2:0];
   assign half     = half_q;
   assign sec_tick = sec_q;

   // R2
   sec_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sec_q |=> !sec_q);

   // R5
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= MAX_CNT);

   // R6
   sidx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sidx_q <= LONG_LAST);

endmodule

// File: rtl/presc_period_tap.sv
module presc_period_tap
   import rtc_presc_pkg::*;
#(
   parameter int unsigned TICKS_PER_SEC = 32768
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       adv,
   input  logic       wrap,
   input  logic       half,
   input  logic [$clog2(TICKS_PER_SEC)-2:0] nxt_lo,
   input  logic [3:0] code,
   input  logic       clr,
   output logic       flag
);

   localparam int LOG2 = $clog2(TICKS_PER_SEC);

   logic [15:0] hit_v;
   logic        fire, flag_q;

   for (genvar c = 0; c < 16; c++) begin : g_code
      if (c < PER_CODE_MIN) begin : g_off
         assign hit_v[c] = 1'b0;
      end else if (c < PER_CODE_ONE_SEC) begin : g_sub
         localparam int K = LOG2 + c - PER_CODE_ONE_SEC;
         if (K == 0) begin : g_every
            assign hit_v[c] = 1'b1;
         end else begin : g_mask
            assign hit_v[c] = (nxt_lo[K-1:0] == '0);
         end
      end else if (c == PER_CODE_ONE_SEC) begin : g_one
         assign hit_v[c] = wrap;
      end else begin : g_two
         assign hit_v[c] = wrap & half;
      end
   end

   assign fire = adv & hit_v[code];

   always_ff @(posedge clk) begin
      if (!rst_n)
         flag_q <= 1'b0;
      else if (fire)
         flag_q <= 1'b1;
      else if (clr)
         flag_q <= 1'b0;
   end

   assign flag = flag_q;

   // R10
   flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> $past(fire));

   // R9
   code_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (code < 4'(PER_CODE_MIN)) |-> !fire);

endmodule

// File: rtl/presc_ready.sv
module presc_ready #(
   parameter int unsigned TICKS_PER_SEC = 32768
)(
   input  logic clk,
   input  logic rst_n,
   input  logic adv,
   output logic ready
);

   localparam int unsigned READY_ADV = TICKS_PER_SEC / 128;
   localparam int unsigned RW        = $clog2(READY_ADV);
   localparam logic [RW-1:0] LAST    = RW'(READY_ADV - 1);

   logic [RW-1:0] rc_q;
   logic          ready_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rc_q    <= '0;
         ready_q <= 1'b0;
      end else if (adv && !ready_q) begin
         if (rc_q == LAST)
            ready_q <= 1'b1;
         else
            rc_q <= rc_q + 1'b1;
      end
   end

   assign ready = ready_q;

   // R11
   ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ready_q |=> ready_q);

endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
   import rtc_presc_pkg::*;
#(
   parameter int unsigned TICKS_PER_SEC = 32768,
   parameter int unsigned SHORT_SECS    = 10,
   parameter int unsigned LONG_SECS     = 60
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       osc_tick,
   input  logic       run,
   input  logic       auto_adj_en,
   input  logic       ivl_short,
   input  logic       trim_we,
   input  logic [7:0] trim_wdata,
   output logic [7:0] trim_rdata,
   input  logic [3:0] per_code,
   input  logic       per_ie,
   input  logic       per_clr,
   output logic       sec_tick,
   output logic       per_flag,
   output logic       per_irq,
   output logic       cnt_ready
);

   localparam int unsigned LOG2 = $clog2(TICKS_PER_SEC);

   if ((32'd1 << LOG2) != TICKS_PER_SEC || LOG2 < MIN_LOG2_TICKS) begin : g_bad_ticks
      $error("TICKS_PER_SEC must be a power of two of at least 256");
   end
   if (SHORT_SECS < 2 || LONG_SECS <= SHORT_SECS) begin : g_bad_ivl
      $error("need 2 <= SHORT_SECS < LONG_SECS");
   end

   trim_t           trim_q;
   logic            ivl_q, adv, wrap, half, flag;
   logic [LOG2-2:0] nxt_lo;

   assign adv = osc_tick & run;

   presc_trim_reg u_trim (
      .clk         (clk),
      .rst_n       (rst_n),
      .we          (trim_we),
      .wdata       (trim_t'(trim_wdata)),
      .ivl_short_in(ivl_short),
      .trim_q      (trim_q),
      .ivl_short_q (ivl_q)
   );

   presc_sec_div #(
      .TICKS_PER_SEC(TICKS_PER_SEC),
      .SHORT_SECS   (SHORT_SECS),
      .LONG_SECS    (LONG_SECS)
   ) u_div (
      .clk        (clk),
      .rst_n      (rst_n),
      .adv        (adv),
      .auto_adj_en(auto_adj_en),
      .ivl_short  (ivl_q),
      .trim       (trim_q),
      .wrap       (wrap),
      .half       (half),
      .sec_tick   (sec_tick),
      .nxt_lo     (nxt_lo)
   );

   presc_period_tap #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_tap (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (adv),
      .wrap  (wrap),
      .half  (half),
      .nxt_lo(nxt_lo),
      .code  (per_code),
      .clr   (per_clr),
      .flag  (flag)
   );

   presc_ready #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_rdy (
      .clk  (clk),
      .rst_n(rst_n),
      .adv  (adv),
      .ready(cnt_ready)
   );

   assign trim_rdata = trim_q;
   assign per_flag   = flag;
   assign per_irq    = flag & per_ie;

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> (!sec_tick && !per_flag && !cnt_ready && trim_rdata == 8'h00));

endmodule

// File: tb/tb_rtc_prescaler.sv
module tb_rtc_prescaler;

   localparam int TPS = 256, SHORT = 10, LONG = 60, LOG2 = 8, READY = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic osc_tick, run = 1'b0, auto_adj_en = 1'b0, ivl_short = 1'b1;
   logic trim_we = 1'b0, per_ie = 1'b0, per_clr;
   logic [7:0] trim_wdata = 8'h00, trim_rdata;
   logic [3:0] per_code = 4'd0;
   logic sec_tick, per_flag, per_irq, cnt_ready;

   always #2 clk = ~clk;

   rtc_prescaler #(.TICKS_PER_SEC(TPS), .SHORT_SECS(SHORT), .LONG_SECS(LONG)) dut (
      .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .run(run),
      .auto_adj_en(auto_adj_en), .ivl_short(ivl_short),
      .trim_we(trim_we), .trim_wdata(trim_wdata), .trim_rdata(trim_rdata),
      .per_code(per_code), .per_ie(per_ie), .per_clr(per_clr),
      .sec_tick(sec_tick), .per_flag(per_flag), .per_irq(per_irq), .cnt_ready(cnt_ready));

   int total = 0, bad = 0, cyc = 0;
   int tick_div = 1, osc_ph = 0;
   bit chk_on = 1'b0, auto_clr = 1'b0, man_clr = 1'b0, irq_prev = 1'b0;
   int irq_rises = 0, acc = 0, acc_mark = 0;
   int lens[$];

   // model state
   int m_cnt, m_sidx, m_half, m_trim, m_ivl, m_flag, m_sec, m_ready, m_rc;

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   always @(posedge clk) begin
      #1;
      osc_ph++;
      osc_tick = ((osc_ph % tick_div) == 0);
      per_clr  = (auto_clr && irq_prev) || man_clr;
   end

   // behavioural reference, advanced on every clock edge
   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_sidx = 0; m_half = 0; m_trim = 0; m_ivl = 0;
         m_flag = 0; m_sec = 0; m_ready = 0; m_rc = 0;
      end else begin
         int mode, n, intv, len, nxt, code;
         bit adv, wrap, fire;
         adv  = osc_tick && run;
         mode = (m_trim >> 6) & 3;
         n    = m_trim & 63;
         intv = m_ivl ? SHORT : LONG;
         len  = TPS;
         if (auto_adj_en && m_sidx >= intv - 1) begin
            if (mode == 1) len = TPS - n;
            else if (mode == 2) len = TPS + n;
         end
         wrap = adv && (m_cnt + 1 >= len);
         nxt  = wrap ? 0 : m_cnt + 1;
         code = int'(per_code);
         fire = 1'b0;
         if (adv) begin
            if (code >= 6 && code <= 13) fire = ((nxt % (1 << (LOG2 + code - 14))) == 0);
            else if (code == 14) fire = wrap;
            else if (code == 15) fire = wrap && (m_half == 1);
         end
         if (adv) acc++;
         m_sec = wrap;
         if (adv) m_cnt = nxt;
         if (wrap) begin
            m_sidx = (m_sidx >= intv - 1) ? 0 : m_sidx + 1;
            m_half = 1 - m_half;
         end
         if (fire) m_flag = 1;
         else if (per_clr) m_flag = 0;
         if (adv && !m_ready) begin
            if (m_rc == READY - 1) m_ready = 1;
            else m_rc++;
         end
         if (mode == 0) m_ivl = ivl_short;
         if (trim_we) m_trim = int'(trim_wdata);
      end
   end

   always @(negedge clk) begin
      if (chk_on) begin
         chk("R2/R4/R5 sec_tick", int'(sec_tick), m_sec);
         chk("R3 trim_rdata", int'(trim_rdata), m_trim);
         chk("R9/R10 per_flag", int'(per_flag), m_flag);
         chk("R10 per_irq", int'(per_irq), m_flag & int'(per_ie));
         chk("R11 cnt_ready", int'(cnt_ready), m_ready);
      end
      if (sec_tick) begin
         lens.push_back(acc - acc_mark);
         acc_mark = acc;
      end
      if (per_irq && !irq_prev) irq_rises++;
      irq_prev = per_irq;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000) begin
         total++; bad++;
         $display("FAIL watchdog R2 actual=%0d expected=%0d", cyc, 190000);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic write_trim(input logic [7:0] v);
      step(); trim_we = 1'b1; trim_wdata = v;
      step(); trim_we = 1'b0;
   endtask

   task automatic wait_sec();
      do @(negedge clk); while (!sec_tick);
   endtask

   task automatic collect(input int n);
      lens.delete();
      while (lens.size() < n) @(negedge clk);
   endtask

   function automatic int count_len(input int v);
      int k = 0;
      foreach (lens[i]) if (lens[i] == v) k++;
      return k;
   endfunction

   task automatic rise_window(input int secs, output int n);
      wait_sec();
      step();
      irq_rises = 0;
      repeat (secs) wait_sec();
      step();
      n = irq_rises;
   endtask

   initial begin
      int n;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset values
      chk("R1 sec_tick", int'(sec_tick), 0);
      chk("R1 per_flag", int'(per_flag), 0);
      chk("R1 per_irq", int'(per_irq), 0);
      chk("R1 cnt_ready", int'(cnt_ready), 0);
      chk("R1 trim_rdata", int'(trim_rdata), 0);
      chk_on = 1'b1;
      step(); rst_n = 1'b1;

      // R11: ready after TPS/128 advances, slow ticks
      tick_div = 3; run = 1'b1;
      step();
      chk("R11 not ready yet", int'(cnt_ready), 0);
      repeat (12) step();
      chk("R11 ready", int'(cnt_ready), 1);

      // R2: plain seconds with sparse ticks
      tick_div = 2;
      wait_sec();
      collect(3);
      chk("R2 seconds at nominal", count_len(TPS), 3);
      tick_div = 1;

      // R4: add trim on short interval
      auto_adj_en = 1'b1;
      wait_sec(); write_trim(8'h45);
      collect(10);
      chk("R4 shortened seconds", count_len(TPS - 5), 1);
      chk("R4 nominal seconds", count_len(TPS), 9);
      chk("R3 readback add", int'(trim_rdata), 8'h45);

      // R5: subtract trim
      wait_sec(); write_trim(8'h87);
      collect(10);
      chk("R5 stretched seconds", count_len(TPS + 7), 1);
      chk("R3 readback sub", int'(trim_rdata), 8'h87);

      // R8: auto adjust disabled
      auto_adj_en = 1'b0;
      collect(10);
      chk("R8 no correction", count_len(TPS), 10);

      // R3: mode 3 treated as none
      auto_adj_en = 1'b1;
      wait_sec(); write_trim(8'hC5);
      collect(10);
      chk("R3 reserved mode", count_len(TPS), 10);

      // R6: long interval
      wait_sec(); write_trim(8'h00);
      ivl_short = 1'b0;
      step(); step();
      write_trim(8'h43);
      collect(61);
      void'(lens.pop_front());
      chk("R6 one correction per long interval", count_len(TPS - 3), 1);

      // R7: interval input ignored while mode nonzero
      ivl_short = 1'b1;
      collect(60);
      chk("R7 interval held", count_len(TPS - 3), 1);

      // R9: periodic codes
      write_trim(8'h00);
      auto_adj_en = 1'b0; per_ie = 1'b1; auto_clr = 1'b1;
      per_code = 4'd8;
      rise_window(1, n); chk("R9 code 8 per second", n, 64);
      per_code = 4'd13;
      rise_window(1, n); chk("R9 code 13 per second", n, 2);
      per_code = 4'd14;
      rise_window(2, n); chk("R9 code 14 over 2 s", n, 2);
      per_code = 4'd15;
      rise_window(4, n); chk("R9 code 15 over 4 s", n, 2);
      per_code = 4'd3;
      rise_window(1, n); chk("R9 code 3 silent", n, 0);
      chk("R9 code 3 flag low", int'(per_flag), 0);

      // R10: flag sticky, gated by enable, cleared by per_clr
      auto_clr = 1'b0; per_ie = 1'b0; per_code = 4'd14;
      wait_sec();
      chk("R10 flag set", int'(per_flag), 1);
      chk("R10 irq masked", int'(per_irq), 0);
      repeat (5) step();
      chk("R10 flag sticky", int'(per_flag), 1);
      per_ie = 1'b1;
      @(negedge clk);
      chk("R10 irq on", int'(per_irq), 1);
      man_clr = 1'b1;
      @(negedge clk); @(negedge clk);
      man_clr = 1'b0;
      @(negedge clk);
      chk("R10 flag cleared", int'(per_flag), 0);

      repeat (4) step();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule